// File: doc/BRIEF.md
# Compare Flags and Branch Unit

This block keeps the condition-code state of a small 32-bit processor and resolves its conditional branches. A compare strobe captures how two register operands relate, both as signed and as unsigned numbers, into a five-bit flag register in a single step. A branch request presents the 16-bit branch instruction and the current program counter. In the same cycle the block returns whether the branch is taken, the following program counter, and a flag for an unsupported condition code.

The branch side is purely combinational and reads only the registered flags. A compare and a branch issued in the same cycle therefore see the flags from before that compare. The instruction holds a 4-bit condition code in bits 13:10 and a 10-bit signed halfword displacement in bits 9:0. Bits 15:14 are ignored. Widths, field positions and the target adder arrangement are parameters.

Top module: `cmpbr_unit`

## Requirements
- R1: After reset, `flags_o` is 0.
- R2: One cycle after a compare (`cmp_en` high) of equal operands, `flags_o` is exactly 5'b00001 (bit 0 = equal).
- R3: One cycle after a compare of unequal operands, bit 0 is 0, bit 1 is set when `op_a` < `op_b` as signed numbers, and bit 2 is set when `op_a` > `op_b` as signed numbers.
- R4: One cycle after a compare of unequal operands, bit 4 is set when `op_a` < `op_b` unsigned, and bit 3 is set when `op_a` > `op_b` unsigned.
- R5: While `cmp_en` is low, `flags_o` keeps its value whatever the operands do.
- R6: A taken branch gives `pc_next` = `pc_in` + 2 + 2 * sign-extended `br_insn[9:0]`.
- R7: A legal branch that is not taken gives `pc_next` = `pc_in` + 2.
- R8: Condition codes (bits 13:10) select the test on the flags: 0 equal, 1 not equal, 2 signed less, 3 signed greater, 4 unsigned less, 5 unsigned greater, 6 signed greater or equal, 7 signed less or equal, 8 unsigned greater or equal, 9 unsigned less or equal.
- R9: With `br_en` high and a condition code of 10 to 15, `br_illegal` is 1, `br_taken` is 0 and `pc_next` equals `pc_in`.
- R10: With `br_en` low, `br_taken` and `br_illegal` are 0 and `pc_next` is `pc_in` + 2.
- R11: A branch in the same cycle as a compare is decided on the flags held before that compare.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_en | input | 1 | Compare strobe; latches flags at the next edge |
| op_a | input | 32 | First compare operand |
| op_b | input | 32 | Second compare operand |
| br_en | input | 1 | Branch request |
| br_insn | input | 16 | Branch instruction: [13:10] condition, [9:0] halfword offset |
| pc_in | input | 32 | Program counter of the branch |
| flags_o | output | 5 | Flags: 0 eq, 1 signed lt, 2 signed gt, 3 unsigned gt, 4 unsigned lt |
| br_taken | output | 1 | Branch taken |
| br_illegal | output | 1 | Unsupported condition code |
| pc_next | output | 32 | Next program counter |

## Verification
The properties assume that `cmp_en`, `br_en` and the operand, instruction and PC inputs are known and steady around each rising edge. They also assume that reset is asserted before the first compare. The bench drives every input on the falling edge, so each value is settled for half a period before the design samples it. It draws operands from a small pool that mixes fully random words with equal pairs, sign-boundary values and values that differ only in the top bit. All sixteen condition codes appear, so the illegal range is exercised together with the legal ones.

// File: rtl/cmpbr_pkg.sv
package cmpbr_pkg;
   localparam int FLAG_N = 5;
   localparam int F_EQ   = 0;
   localparam int F_SLT  = 1;
   localparam int F_SGT  = 2;
   localparam int F_UGT  = 3;
   localparam int F_ULT  = 4;
   localparam int CC_W   = 4;
   localparam int CC_COUNT = 10;

   typedef logic [FLAG_N-1:0] flags_t;

   // condition codes; the numbering is decoded by the instruction stream (R8)
   typedef enum logic [CC_W-1:0] {
      CC_EQ  = 4'd0,
      CC_NE  = 4'd1,
      CC_SLT = 4'd2,
      CC_SGT = 4'd3,
      CC_ULT = 4'd4,
      CC_UGT = 4'd5,
      CC_SGE = 4'd6,
      CC_SLE = 4'd7,
      CC_UGE = 4'd8,
      CC_ULE = 4'd9
   } cc_e;
endpackage

// File: rtl/cmpbr_compare.sv
module cmpbr_compare
   import cmpbr_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output flags_t          flags_nxt
);
   logic s_less;
   logic u_less;

   assign s_less = $signed(a) < $signed(b);
   assign u_less = a < b;

   always_comb begin
      flags_nxt = '0;
      if (a == b) begin
         flags_nxt[F_EQ] = 1'b1;                 // R2
      end else begin
         flags_nxt[F_SLT] = s_less;              // R3
         flags_nxt[F_SGT] = ~s_less;
         flags_nxt[F_ULT] = u_less;              // R4
         flags_nxt[F_UGT] = ~u_less;
      end
   end
endmodule

// File: rtl/cmpbr_flagreg.sv
module cmpbr_flagreg
   import cmpbr_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   load,
   input  flags_t d,
   output flags_t q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;                                // R1
      end else if (load) begin
         q <= d;                                 // R5: held otherwise
      end
   end
endmodule

// File: rtl/cmpbr_branch.sv
module cmpbr_branch
   import cmpbr_pkg::*;
#(
   parameter int XLEN         = 32,
   parameter int OFF_W        = 10,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic             en,
   input  logic [CC_W-1:0]  cc,
   input  logic [OFF_W-1:0] off_raw,
   input  logic [XLEN-1:0]  pc,
   input  flags_t           flags,
   output logic             taken,
   output logic             illegal,
   output logic [XLEN-1:0]  pc_next
);
   localparam int EXT_W = XLEN - OFF_W - 1;

   logic            legal;
   logic            hit;
   logic [XLEN-1:0] disp;

   assign disp = {{EXT_W{off_raw[OFF_W-1]}}, off_raw, 1'b0};   // R6

   always_comb begin
      legal = 1'b1;
      hit   = 1'b0;
      case (cc)
         CC_EQ:  hit = flags[F_EQ];
         CC_NE:  hit = ~flags[F_EQ];
         CC_SLT: hit = flags[F_SLT];
         CC_SGT: hit = flags[F_SGT];
         CC_ULT: hit = flags[F_ULT];
         CC_UGT: hit = flags[F_UGT];
         CC_SGE: hit = flags[F_SGT] | flags[F_EQ];
         CC_SLE: hit = flags[F_SLT] | flags[F_EQ];
         CC_UGE: hit = flags[F_UGT] | flags[F_EQ];
         CC_ULE: hit = flags[F_ULT] | flags[F_EQ];
         default: legal = 1'b0;                  // R9
      endcase
   end

   assign taken   = en & legal & hit;
   assign illegal = en & ~legal;

   generate
      if (SHARED_ADDER) begin : g_shared
         logic [XLEN-1:0] addend;
         assign addend  = taken ? disp + XLEN'(2) : XLEN'(2);
         assign pc_next = illegal ? pc : pc + addend;
      end else begin : g_split
         logic [XLEN-1:0] seq_pc;
         logic [XLEN-1:0] tgt_pc;
         assign seq_pc  = pc + XLEN'(2);
         assign tgt_pc  = seq_pc + disp;
         assign pc_next = illegal ? pc : (taken ? tgt_pc : seq_pc);
      end
   endgenerate
endmodule

// File: rtl/cmpbr_unit.sv
module cmpbr_unit
   import cmpbr_pkg::*;
#(
   parameter int XLEN         = 32,
   parameter int INSN_W       = 16,
   parameter int OFF_W        = 10,
   parameter int CC_LSB       = 10,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmp_en,
   input  logic [XLEN-1:0]       op_a,
   input  logic [XLEN-1:0]       op_b,
   input  logic                  br_en,
   input  logic [INSN_W-1:0]     br_insn,
   input  logic [XLEN-1:0]       pc_in,
   output logic [FLAG_N-1:0]     flags_o,
   output logic                  br_taken,
   output logic                  br_illegal,
   output logic [XLEN-1:0]       pc_next
);
   localparam int CC_MSB = CC_LSB + CC_W - 1;

   generate
      if (OFF_W + 1 >= XLEN) begin : g_bad_off
         $error("cmpbr_unit: OFF_W too wide for XLEN");
      end
      if (OFF_W > CC_LSB) begin : g_bad_overlap
         $error("cmpbr_unit: offset field overlaps condition field");
      end
      if (CC_MSB >= INSN_W) begin : g_bad_cc
         $error("cmpbr_unit: condition field outside instruction");
      end
      if (CC_MSB < INSN_W - 1) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^br_insn[INSN_W-1:CC_MSB+1];
      end
      if (OFF_W < CC_LSB) begin : g_mid
         logic unused_mid;
         assign unused_mid = ^br_insn[CC_LSB-1:OFF_W];
      end
   endgenerate

   flags_t flags_nxt;
   flags_t flags_q;

   cmpbr_compare #(.XLEN(XLEN)) u_cmp (
      .a         (op_a),
      .b         (op_b),
      .flags_nxt (flags_nxt)
   );

   cmpbr_flagreg u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (cmp_en),
      .d     (flags_nxt),
      .q     (flags_q)
   );

   cmpbr_branch #(
      .XLEN         (XLEN),
      .OFF_W        (OFF_W),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_br (
      .en      (br_en),
      .cc      (br_insn[CC_MSB:CC_LSB]),
      .off_raw (br_insn[OFF_W-1:0]),
      .pc      (pc_in),
      .flags   (flags_q),                        // R11: registered flags only
      .taken   (br_taken),
      .illegal (br_illegal),
      .pc_next (pc_next)
   );

   assign flags_o = flags_q;
endmodule

// File: rtl/cmpbr_checker.sv
module cmpbr_checker
   import cmpbr_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int INSN_W = 16,
   parameter int CC_LSB = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmp_en,
   input logic [XLEN-1:0]   op_a,
   input logic [XLEN-1:0]   op_b,
   input logic              br_en,
   input logic [INSN_W-1:0] br_insn,
   input logic [XLEN-1:0]   pc_in,
   input logic [FLAG_N-1:0] flags_o,
   input logic              br_taken,
   input logic              br_illegal,
   input logic [XLEN-1:0]   pc_next
);
   logic [CC_W-1:0] cc;
   assign cc = br_insn[CC_LSB+CC_W-1:CC_LSB];

   AST_EQ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_en && op_a == op_b) |=> (flags_o == 5'b00001));               // R2
   AST_SIGNED_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_en && op_a != op_b) |=> ($countones(flags_o[F_SGT:F_SLT]) == 1 && !flags_o[F_EQ])); // R3
   AST_UNSIGNED_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_en && op_a != op_b) |=> ($countones({flags_o[F_ULT], flags_o[F_UGT]}) == 1)); // R4
   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_en |=> $stable(flags_o));                                      // R5
   AST_NOT_TAKEN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      (br_en && !br_illegal && !br_taken) |-> (pc_next == pc_in + XLEN'(2))); // R7
   AST_ILLEGAL_CC: assert property (@(posedge clk) disable iff (!rst_n)
      (br_en && cc >= CC_W'(CC_COUNT)) |-> (br_illegal && !br_taken && pc_next == pc_in)); // R9
   AST_LEGAL_CC: assert property (@(posedge clk) disable iff (!rst_n)
      (br_en && cc < CC_W'(CC_COUNT)) |-> !br_illegal);                   // R8
   AST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !br_en |-> (!br_taken && !br_illegal && pc_next == pc_in + XLEN'(2))); // R10
endmodule

bind cmpbr_unit cmpbr_checker #(
   .XLEN   (XLEN),
   .INSN_W (INSN_W),
   .CC_LSB (CC_LSB)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmp_en     (cmp_en),
   .op_a       (op_a),
   .op_b       (op_b),
   .br_en      (br_en),
   .br_insn    (br_insn),
   .pc_in      (pc_in),
   .flags_o    (flags_o),
   .br_taken   (br_taken),
   .br_illegal (br_illegal),
   .pc_next    (pc_next)
);

// File: tb/test_cmpbr_unit.sv
`timescale 1ns/1ps
module test_cmpbr_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmp_en = 1'b0;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic        br_en = 1'b0;
   logic [15:0] br_insn = '0;
   logic [31:0] pc_in = '0;
   logic [4:0]  flags_o;
   logic        br_taken;
   logic        br_illegal;
   logic [31:0] pc_next;

   int total = 0;
   int bad = 0;
   logic [4:0] model_flags = '0;

   always #2.5 clk = ~clk;

   cmpbr_unit i_cmpbr_unit (
      .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .op_a(op_a), .op_b(op_b),
      .br_en(br_en), .br_insn(br_insn), .pc_in(pc_in), .flags_o(flags_o),
      .br_taken(br_taken), .br_illegal(br_illegal), .pc_next(pc_next)
   );

   function automatic logic [4:0] exp_flags(input logic [31:0] a, input logic [31:0] b);
      logic [4:0] f = '0;
      if (a == b) f[0] = 1'b1;
      else begin
         f[1] = $signed(a) < $signed(b);
         f[2] = $signed(a) > $signed(b);
         f[4] = a < b;
         f[3] = a > b;
      end
      return f;
   endfunction

   function automatic logic exp_hit(input logic [3:0] c, input logic [4:0] f);
      case (c)
         4'd0: return f[0];
         4'd1: return !f[0];
         4'd2: return f[1];
         4'd3: return f[2];
         4'd4: return f[4];
         4'd5: return f[3];
         4'd6: return f[2] | f[0];
         4'd7: return f[1] | f[0];
         4'd8: return f[3] | f[0];
         4'd9: return f[4] | f[0];
         default: return 1'b0;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // compare then check flags one edge later
   task automatic do_cmp(input logic [31:0] a, input logic [31:0] b);
      logic [4:0] e;
      @(negedge clk);
      br_en = 1'b0; cmp_en = 1'b1; op_a = a; op_b = b;
      @(posedge clk); #1;
      cmp_en = 1'b0;
      e = exp_flags(a, b);
      model_flags = e;
      if (a == b) check("R2 flags equal", 32'(flags_o), 32'(e));
      else begin
         check("R3 signed flags", 32'(flags_o[2:0]), 32'(e[2:0]));
         check("R4 unsigned flags", 32'(flags_o[4:3]), 32'(e[4:3]));
      end
   endtask

   task automatic do_br(input logic [15:0] insn, input logic [31:0] pc);
      logic [3:0]  c;
      logic [31:0] disp;
      logic        t;
      @(negedge clk);
      cmp_en = 1'b0; br_en = 1'b1; br_insn = insn; pc_in = pc;
      #1;
      c = insn[13:10];
      disp = {{21{insn[9]}}, insn[9:0], 1'b0};
      t = exp_hit(c, model_flags);
      if (c > 4'd9) begin
         check("R9 illegal flag", 32'(br_illegal), 32'd1);
         check("R9 not taken", 32'(br_taken), 32'd0);
         check("R9 pc unchanged", pc_next, pc);
      end else begin
         check("R8 taken decision", {31'd0, br_taken}, {31'd0, t});
         if (t) check("R6 target pc", pc_next, pc + 32'd2 + disp);
         else   check("R7 sequential pc", pc_next, pc + 32'd2);
      end
      br_en = 1'b0;
   endtask

   function automatic logic [31:0] pick_val(input logic [31:0] other);
      case ($urandom_range(0, 5))
         0: return other;
         1: return 32'h8000_0000;
         2: return 32'h7fff_ffff;
         3: return other ^ 32'h8000_0000;
         4: return 32'hffff_ffff;
         default: return $urandom;
      endcase
   endfunction

   initial begin : watchdog
      #200000;
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd20240607));
      repeat (3) @(posedge clk);
      #1 check("R1 reset flags", 32'(flags_o), 32'd0);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      check("R1 flags after release", 32'(flags_o), 32'd0);
      check("R10 idle taken", {31'd0, br_taken}, 32'd0);
      check("R10 idle illegal", {31'd0, br_illegal}, 32'd0);
      pc_in = 32'h0000_1000; #1;
      check("R10 idle pc", pc_next, 32'h0000_1002);

      // directed corners
      do_cmp(32'h1234_5678, 32'h1234_5678);
      do_br({2'b11, 4'd0, 10'h3ff}, 32'h0000_0100);        // beq back by 2 -> 0x100
      do_br({2'b00, 4'd1, 10'h010}, 32'h0000_0100);
      do_cmp(32'h8000_0000, 32'h0000_0001);                // signed less, unsigned greater
      do_br({2'b11, 4'd2, 10'h200}, 32'h0000_4000);        // most negative offset
      do_br({2'b11, 4'd5, 10'h1ff}, 32'hffff_fff0);        // wrap around
      do_br({2'b11, 4'd4, 10'h004}, 32'h0000_4000);
      do_br({2'b11, 4'd8, 10'h004}, 32'h0000_4000);
      do_br({2'b11, 4'd10, 10'h004}, 32'h0000_4000);
      do_br({2'b11, 4'd15, 10'h3f0}, 32'h0000_4000);

      // R5: operands move with no strobe
      @(negedge clk);
      op_a = 32'd5; op_b = 32'd5;
      @(posedge clk); #1;
      check("R5 flags held", 32'(flags_o), 32'(model_flags));

      // R11: compare and branch in the same cycle
      @(negedge clk);
      cmp_en = 1'b1; op_a = 32'd9; op_b = 32'd9;
      br_en = 1'b1; br_insn = {2'b11, 4'd0, 10'h008}; pc_in = 32'h200;
      #1;
      check("R11 old flags used", {31'd0, br_taken}, 32'd0);
      check("R11 pc uses old flags", pc_next, 32'h202);
      @(posedge clk); #1;
      cmp_en = 1'b0; br_en = 1'b0;
      model_flags = 5'b00001;
      check("R2 flags after same cycle compare", 32'(flags_o), 32'd1);

      // constrained random
      for (int i = 0; i < 300; i++) begin
         logic [31:0] a;
         logic [31:0] b;
         a = $urandom;
         b = pick_val(a);
         if ($urandom_range(0, 1) == 1) do_cmp(a, b);
         else do_cmp(b, a);
         for (int j = 0; j < 3; j++) begin
            do_br(16'($urandom), $urandom & 32'hffff_fffe);
         end
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule